// File: doc/BRIEF.md
# SDRAM Bank Configuration and Address Decoder

This block is the configuration front end of a four-bank SDRAM controller. Software reaches it through two register-bus ports. Writing the address port stores an internal register offset. The data port then reads or writes the register that this offset selects. Behind the data port sit the bus error status and error address registers, a controller configuration word, a read-only status word, the refresh and idle timer settings, the ECC configuration and ECC error status words, and one control word per memory bank. Each register keeps only its defined bits on a write.

Each bank control word describes a window in the system address space. The window has a 9-bit base, aligned to 8 MiB, and a 3-bit size code. The size is 4 MiB shifted left by the code. Every cycle the decoder compares an incoming system address against all enabled windows. It returns a one-hot hit vector and the byte offset inside the winning bank. Switching the controller on or off updates status flags. Writing the ECC error status word drives an interrupt line.

Top module: `sdram_cfg_decoder`

## Requirements
- R1: Writing the address port (bus_sel=0) stores bits 7:0 as the offset, and reading with bus_sel=0 returns it zero-extended. Reading with bus_sel=1 returns the selected register. The timing offset 0x80 and every offset not listed here read 0xFFFFFFFF, and writing them changes no readable register.
- R2: After reset, config (0x20) reads 0x00800000, refresh (0x30) reads 0x05F00000 and idle (0x34) reads 0x07C00000. All other listed registers read 0, and ecc_irq is 0.
- R3: The bus error status words at 0x00 and 0x08 are write-one-to-clear. The error address word at 0x10 stores the written value as is.
- R4: A config write stores the value ANDed with 0xFFE00000. When bit 31 of config goes from 0 to 1, status (0x24) bit 31 clears; when it goes from 1 to 0, status bit 31 sets. Writes to status are ignored.
- R5: When config bit 30 goes from 0 to 1, status bit 30 sets; when it goes from 1 to 0, status bit 30 clears.
- R6: The refresh word stores the value AND 0x3FF80000. The idle word stores (value AND 0xF8000000) OR 0x07C00000. The ECC config word (0x94) stores the value AND 0x00F00000.
- R7: The ECC error status word (0x98) stores the value AND 0xFFF0F000. From the cycle after the write, ecc_irq is 1 exactly when the stored word is nonzero.
- R8: Bank control word i sits at offset 0x40+4*i and stores the value AND 0xFFDEE001. Bit 0 is valid, bits 31:23 are the base and bits 19:17 are the size code.
- R9: Bank i hits when config bit 31 is 1, its valid bit is 1, its code is not 7, and base*8MiB <= sys_addr < base*8MiB + (4 MiB << code). The hit appears combinationally from sys_addr.
- R10: bank_hit is one-hot or zero. When several banks match, only the lowest-numbered one is reported.
- R11: bank_offset equals sys_addr minus the winning bank's base address, and is 0 when no bank hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_sel | input | 1 | 0 = address port, 1 = data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected port |
| sys_addr | input | 32 | System address to decode |
| bank_hit | output | 4 | One-hot bank hit vector |
| bank_offset | output | 32 | Offset inside the winning bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Suppose the stored offset, a bank word or the enable flag is wrong inside the block. The bank hit vector or the offset then goes wrong in the same cycle for any address near that window. A read of the selected register shows the fault directly after one address-port write. The status flags and the interrupt line are registered beside the word that triggers them. A missed edge therefore shows one cycle after the config or ECC write, and it stays visible until the next such write. The reference model compares hit, offset, interrupt and read data on every clock. Directed cases target edges of the size windows, overlapping banks, the invalid size code and the enable transitions in both directions.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int DW            = 32;
    localparam int OFS_W         = 8;
    localparam int BASE_W        = 9;
    localparam int BASE_LSB      = DW - BASE_W;
    localparam int CODE_W        = 3;
    localparam int CODE_LSB      = 17;
    localparam int MIN_SIZE_LOG2 = 22;

    typedef enum logic {
        PORT_ADDR = 1'b0,
        PORT_DATA = 1'b1
    } port_e;

    localparam logic [OFS_W-1:0] OFS_BESR_A  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_BESR_B  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_BEAR    = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CFG     = 8'h20;
    localparam logic [OFS_W-1:0] OFS_STAT    = 8'h24;
    localparam logic [OFS_W-1:0] OFS_RFSH    = 8'h30;
    localparam logic [OFS_W-1:0] OFS_IDLE    = 8'h34;
    localparam logic [OFS_W-1:0] OFS_BANK0   = 8'h40;
    localparam logic [OFS_W-1:0] OFS_ECC_CFG = 8'h94;
    localparam logic [OFS_W-1:0] OFS_ECC_ERR = 8'h98;

    localparam logic [DW-1:0] MASK_CFG     = 32'hFFE0_0000;
    localparam logic [DW-1:0] MASK_BANK    = 32'hFFDE_E001;
    localparam logic [DW-1:0] MASK_RFSH    = 32'h3FF8_0000;
    localparam logic [DW-1:0] MASK_IDLE    = 32'hF800_0000;
    localparam logic [DW-1:0] FIXED_IDLE   = 32'h07C0_0000;
    localparam logic [DW-1:0] MASK_ECC_CFG = 32'h00F0_0000;
    localparam logic [DW-1:0] MASK_ECC_ERR = 32'hFFF0_F000;

    localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
    localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_IDLE = FIXED_IDLE;

    localparam int EN_BIT   = 31;
    localparam int SELF_BIT = 30;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
        logic              valid;
    } bank_win_t;

    function automatic bank_win_t unpack_bank(input logic [DW-1:0] w);
        bank_win_t r;
        r.base  = w[DW-1:BASE_LSB];
        r.code  = w[CODE_LSB+CODE_W-1:CODE_LSB];
        r.valid = w[0];
        return r;
    endfunction

    function automatic logic [OFS_W-1:0] bank_reg_ofs(input int idx);
        return OFS_BANK0 + OFS_W'(idx * 4);
    endfunction

endpackage

// File: rtl/sdc_regfile.sv
module sdc_regfile
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic                           bus_sel,
    input  logic [DW-1:0]                  bus_wdata,
    output logic [DW-1:0]                  bus_rdata,
    output logic [OFS_W-1:0]               cur_ofs,
    output logic                           ctrl_en,
    output logic [1:0]                     stat_hi,
    output logic [NUM_BANKS-1:0][DW-1:0]   bank_words,
    output logic                           ecc_irq
);

    logic [OFS_W-1:0] ofs_q;
    logic [DW-1:0]    besr_a_q, besr_b_q, bear_q, cfg_q;
    logic [DW-1:0]    rfsh_q, idle_q, ecc_cfg_q, ecc_err_q;
    logic [1:0]       stat_q;
    logic [DW-1:0]    bank_q [NUM_BANKS];

    logic          addr_wr, data_wr;
    logic [DW-1:0] cfg_next, ecc_next;

    assign addr_wr  = bus_wr && (bus_sel == PORT_ADDR);
    assign data_wr  = bus_wr && (bus_sel == PORT_DATA);
    assign cfg_next = bus_wdata & MASK_CFG;
    assign ecc_next = bus_wdata & MASK_ECC_ERR;

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q     <= '0;
            besr_a_q  <= '0;
            besr_b_q  <= '0;
            bear_q    <= '0;
            cfg_q     <= RST_CFG;
            stat_q    <= '0;
            rfsh_q    <= RST_RFSH;
            idle_q    <= RST_IDLE;
            ecc_cfg_q <= '0;
            ecc_err_q <= '0;
        end else begin
            if (addr_wr) begin
                ofs_q <= bus_wdata[OFS_W-1:0];
            end
            if (data_wr) begin
                case (ofs_q)
                    OFS_BESR_A:  besr_a_q  <= besr_a_q & ~bus_wdata;
                    OFS_BESR_B:  besr_b_q  <= besr_b_q & ~bus_wdata;
                    OFS_BEAR:    bear_q    <= bus_wdata;
                    OFS_CFG: begin
                        cfg_q <= cfg_next;
                        if (!cfg_q[EN_BIT] && cfg_next[EN_BIT]) begin
                            stat_q[1] <= 1'b0;
                        end else if (cfg_q[EN_BIT] && !cfg_next[EN_BIT]) begin
                            stat_q[1] <= 1'b1;
                        end
                        if (!cfg_q[SELF_BIT] && cfg_next[SELF_BIT]) begin
                            stat_q[0] <= 1'b1;
                        end else if (cfg_q[SELF_BIT] && !cfg_next[SELF_BIT]) begin
                            stat_q[0] <= 1'b0;
                        end
                    end
                    OFS_RFSH:    rfsh_q    <= bus_wdata & MASK_RFSH;
                    OFS_IDLE:    idle_q    <= (bus_wdata & MASK_IDLE) | FIXED_IDLE;
                    OFS_ECC_CFG: ecc_cfg_q <= bus_wdata & MASK_ECC_CFG;
                    OFS_ECC_ERR: ecc_err_q <= ecc_next;
                    default: ;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[g] <= '0;
            end else if (data_wr && (ofs_q == bank_reg_ofs(g))) begin
                bank_q[g] <= bus_wdata & MASK_BANK;
            end
        end
        assign bank_words[g] = bank_q[g];
    end

    always_comb begin
        bus_rdata = '1;
        if (bus_sel == PORT_ADDR) begin
            bus_rdata = DW'(ofs_q);
        end else begin
            case (ofs_q)
                OFS_BESR_A:  bus_rdata = besr_a_q;
                OFS_BESR_B:  bus_rdata = besr_b_q;
                OFS_BEAR:    bus_rdata = bear_q;
                OFS_CFG:     bus_rdata = cfg_q;
                OFS_STAT:    bus_rdata = {stat_q, {(DW-2){1'b0}}};
                OFS_RFSH:    bus_rdata = rfsh_q;
                OFS_IDLE:    bus_rdata = idle_q;
                OFS_ECC_CFG: bus_rdata = ecc_cfg_q;
                OFS_ECC_ERR: bus_rdata = ecc_err_q;
                default:     bus_rdata = '1;
            endcase
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (ofs_q == bank_reg_ofs(i)) begin
                    bus_rdata = bank_q[i];
                end
            end
        end
    end

    assign cur_ofs = ofs_q;
    assign ctrl_en = cfg_q[EN_BIT];
    assign stat_hi = stat_q;
    assign ecc_irq = |ecc_err_q;

endmodule

// File: rtl/sdc_bank_match.sv
module sdc_bank_match
    import sdc_pkg::*;
(
    input  logic [DW-1:0] bank_word,
    input  logic          ctrl_en,
    input  logic [DW-1:0] addr,
    output logic          match,
    output logic [DW-1:0] offset
);

    bank_win_t     win;
    logic [DW:0]   diff;
    logic [DW-1:0] above_size;
    logic [4:0]    size_log2;

    assign win        = unpack_bank(bank_word);
    assign diff       = {1'b0, addr} - {1'b0, win.base, {BASE_LSB{1'b0}}};
    assign offset     = diff[DW-1:0];
    assign size_log2  = 5'(MIN_SIZE_LOG2) + 5'(win.code);
    assign above_size = offset >> size_log2;

    assign match = ctrl_en && win.valid && (win.code != '1)
                 && !diff[DW] && (above_size == '0);

endmodule

// File: rtl/sdc_bank_decode.sv
module sdc_bank_decode
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                         ctrl_en,
    input  logic [NUM_BANKS-1:0][DW-1:0] bank_words,
    input  logic [DW-1:0]                sys_addr,
    output logic [NUM_BANKS-1:0]         bank_hit,
    output logic [DW-1:0]                bank_offset
);

    logic [NUM_BANKS-1:0]         raw_match;
    logic [NUM_BANKS-1:0][DW-1:0] raw_offset;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_match
        sdc_bank_match u_match (
            .bank_word (bank_words[g]),
            .ctrl_en   (ctrl_en),
            .addr      (sys_addr),
            .match     (raw_match[g]),
            .offset    (raw_offset[g])
        );
    end

    always_comb begin
        bank_hit    = '0;
        bank_offset = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (raw_match[i]) begin
                bank_hit    = '0;
                bank_hit[i] = 1'b1;
                bank_offset = raw_offset[i];
            end
        end
    end

endmodule

// File: rtl/sdram_cfg_decoder.sv
module sdram_cfg_decoder
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic                 bus_sel,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [31:0]          sys_addr,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic [31:0]          bank_offset,
    output logic                 ecc_irq
);

    logic [OFS_W-1:0]             cur_ofs;
    logic                         ctrl_en;
    logic [1:0]                   stat_hi;
    logic [NUM_BANKS-1:0][DW-1:0] bank_words;

    sdc_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_sel    (bus_sel),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cur_ofs    (cur_ofs),
        .ctrl_en    (ctrl_en),
        .stat_hi    (stat_hi),
        .bank_words (bank_words),
        .ecc_irq    (ecc_irq)
    );

    sdc_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .ctrl_en     (ctrl_en),
        .bank_words  (bank_words),
        .sys_addr    (sys_addr),
        .bank_hit    (bank_hit),
        .bank_offset (bank_offset)
    );

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_sel,
    input logic [31:0]          bus_wdata,
    input logic [OFS_W-1:0]     cur_ofs,
    input logic                 ctrl_en,
    input logic [1:0]           stat_hi,
    input logic [NUM_BANKS-1:0] bank_hit,
    input logic [31:0]          bank_offset,
    input logic                 ecc_irq
);

    logic ecc_wr, cfg_wr;
    assign ecc_wr = bus_wr && bus_sel && (cur_ofs == OFS_ECC_ERR);
    assign cfg_wr = bus_wr && bus_sel && (cur_ofs == OFS_CFG);

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_hit)); // R10
    AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> (bank_hit == '0)); // R9
    AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (rst)
        (bank_hit != '0) |-> (bank_offset < 32'h1000_0000)); // R9
    AST_OFFSET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bank_hit == '0) |-> (bank_offset == '0)); // R11
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        (ecc_wr && ((bus_wdata & MASK_ECC_ERR) != '0)) |=> ecc_irq); // R7
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        (ecc_wr && ((bus_wdata & MASK_ECC_ERR) == '0)) |=> !ecc_irq); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ecc_wr |=> $stable(ecc_irq)); // R7
    AST_EN_RISE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !ctrl_en && bus_wdata[31]) |=> (ctrl_en && !stat_hi[1])); // R4
    AST_EN_FALL: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && ctrl_en && !bus_wdata[31]) |=> (!ctrl_en && stat_hi[1])); // R4
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(stat_hi)); // R5

endmodule

bind sdram_cfg_decoder sdc_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_sel     (bus_sel),
    .bus_wdata   (bus_wdata),
    .cur_ofs     (cur_ofs),
    .ctrl_en     (ctrl_en),
    .stat_hi     (stat_hi),
    .bank_hit    (bank_hit),
    .bank_offset (bank_offset),
    .ecc_irq     (ecc_irq)
);

// File: tb/sdram_cfg_decoder_tb.sv
module sdram_cfg_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] sys_addr = '0;
    logic [3:0]  bank_hit;
    logic [31:0] bank_offset;
    logic        ecc_irq;

    int checks = 0;
    int errors = 0;
    bit tracking = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic [7:0]  m_ofs;
    logic [31:0] m_besr_a, m_besr_b, m_bear, m_cfg, m_stat, m_rfsh, m_idle;
    logic [31:0] m_ecc_cfg, m_ecc_err;
    logic [31:0] m_bank [4];

    sdram_cfg_decoder u_dut (
        .clk, .rst, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
        .sys_addr, .bank_hit, .bank_offset, .ecc_irq
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic model_reset();
        m_ofs = 0; m_besr_a = 0; m_besr_b = 0; m_bear = 0;
        m_cfg = 32'h0080_0000; m_stat = 0; m_rfsh = 32'h05F0_0000;
        m_idle = 32'h07C0_0000; m_ecc_cfg = 0; m_ecc_err = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    task automatic model_apply(input logic s, input logic [31:0] v);
        logic [31:0] nv;
        if (!s) begin
            m_ofs = v[7:0];
        end else begin
            case (m_ofs)
                8'h00: m_besr_a = m_besr_a & ~v;
                8'h08: m_besr_b = m_besr_b & ~v;
                8'h10: m_bear = v;
                8'h20: begin
                    nv = v & 32'hFFE0_0000;
                    if (!m_cfg[31] && nv[31]) m_stat[31] = 1'b0;
                    if (m_cfg[31] && !nv[31]) m_stat[31] = 1'b1;
                    if (!m_cfg[30] && nv[30]) m_stat[30] = 1'b1;
                    if (m_cfg[30] && !nv[30]) m_stat[30] = 1'b0;
                    m_cfg = nv;
                end
                8'h30: m_rfsh = v & 32'h3FF8_0000;
                8'h34: m_idle = (v & 32'hF800_0000) | 32'h07C0_0000;
                8'h40: m_bank[0] = v & 32'hFFDE_E001;
                8'h44: m_bank[1] = v & 32'hFFDE_E001;
                8'h48: m_bank[2] = v & 32'hFFDE_E001;
                8'h4C: m_bank[3] = v & 32'hFFDE_E001;
                8'h94: m_ecc_cfg = v & 32'h00F0_0000;
                8'h98: m_ecc_err = v & 32'hFFF0_F000;
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] model_read();
        if (!bus_sel) return {24'd0, m_ofs};
        case (m_ofs)
            8'h00: return m_besr_a;
            8'h08: return m_besr_b;
            8'h10: return m_bear;
            8'h20: return m_cfg;
            8'h24: return m_stat;
            8'h30: return m_rfsh;
            8'h34: return m_idle;
            8'h40: return m_bank[0];
            8'h44: return m_bank[1];
            8'h48: return m_bank[2];
            8'h4C: return m_bank[3];
            8'h94: return m_ecc_cfg;
            8'h98: return m_ecc_err;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int model_winner(input logic [31:0] a);
        longint base, size;
        int code;
        if (!m_cfg[31]) return -1;
        for (int i = 0; i < 4; i++) begin
            base = longint'(m_bank[i] & 32'hFF80_0000);
            code = int'((m_bank[i] >> 17) & 7);
            size = longint'(4194304) << code;
            if (m_bank[i][0] && code != 7 && longint'(a) >= base && longint'(a) < base + size)
                return i;
        end
        return -1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (tracking && !done) begin
            int w;
            w = model_winner(sys_addr);
            check("R1", "rdata", bus_rdata, model_read());
            check("R10", "bank_hit", 32'(bank_hit), (w < 0) ? 32'd0 : (32'd1 << w));
            check("R11", "bank_offset", bank_offset,
                  (w < 0) ? 32'd0 : (sys_addr - (m_bank[w] & 32'hFF80_0000)));
            check("R7", "ecc_irq", 32'(ecc_irq), 32'(m_ecc_err != 0));
        end
    end

    task automatic bus_write(input logic s, input logic [31:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_sel = s; bus_wdata = v;
        @(posedge clk);
        model_apply(s, v);
        #1 bus_wr = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] o, input logic [31:0] v);
        bus_write(1'b0, {24'd0, o});
        bus_write(1'b1, v);
    endtask

    task automatic reg_check(input logic [7:0] o, input string req, input logic [31:0] exp);
        bus_write(1'b0, {24'd0, o});
        @(posedge clk); #1 bus_sel = 1'b1;
        @(negedge clk);
        check(req, $sformatf("read offset %02h", o), bus_rdata, exp);
    endtask

    task automatic decode_check(input logic [31:0] a, input string req,
                                input logic [3:0] exp_hit, input logic [31:0] exp_ofs);
        @(posedge clk); #1 sys_addr = a;
        @(negedge clk);
        check(req, $sformatf("hit @%08h", a), 32'(bank_hit), 32'(exp_hit));
        check(req, $sformatf("offset @%08h", a), bank_offset, exp_ofs);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tracking = 1'b1;

        // R2: reset values
        @(negedge clk);
        check("R2", "ecc_irq after reset", 32'(ecc_irq), 32'd0);
        reg_check(8'h20, "R2", 32'h0080_0000);
        reg_check(8'h30, "R2", 32'h05F0_0000);
        reg_check(8'h34, "R2", 32'h07C0_0000);
        reg_check(8'h24, "R2", 32'h0000_0000);
        reg_check(8'h98, "R2", 32'h0000_0000);

        // R1: offset readback, undefined and timing offsets
        bus_write(1'b0, 32'hABCD_125A);
        @(negedge clk);
        check("R1", "address port readback", bus_rdata, 32'h0000_005A);
        reg_check(8'h5A, "R1", 32'hFFFF_FFFF);
        reg_write(8'h80, 32'h1234_5678);
        reg_check(8'h80, "R1", 32'hFFFF_FFFF);

        // R3: bus error words
        reg_write(8'h10, 32'h1234_5678);
        reg_check(8'h10, "R3", 32'h1234_5678);
        reg_write(8'h00, 32'hFFFF_FFFF);
        reg_check(8'h00, "R3", 32'h0000_0000);
        reg_write(8'h08, 32'hFFFF_FFFF);
        reg_check(8'h08, "R3", 32'h0000_0000);

        // R6: write masks
        reg_write(8'h30, 32'hFFFF_FFFF);
        reg_check(8'h30, "R6", 32'h3FF8_0000);
        reg_write(8'h34, 32'h0000_0000);
        reg_check(8'h34, "R6", 32'h07C0_0000);
        reg_write(8'h34, 32'hFFFF_FFFF);
        reg_check(8'h34, "R6", 32'hFFC0_0000);
        reg_write(8'h94, 32'hFFFF_FFFF);
        reg_check(8'h94, "R6", 32'h00F0_0000);

        // R4: status is read-only
        reg_write(8'h24, 32'hFFFF_FFFF);
        reg_check(8'h24, "R4", 32'h0000_0000);

        // R8: bank words
        reg_write(8'h40, 32'h0002_0001);
        reg_write(8'h44, 32'h0080_0001);
        reg_write(8'h48, 32'h000C_0001);
        reg_write(8'h4C, 32'hFFFF_FFFF);
        reg_check(8'h4C, "R8", 32'hFFDE_E001);
        reg_check(8'h44, "R8", 32'h0080_0001);

        // R9: no hit while controller disabled
        decode_check(32'h0010_0000, "R9", 4'b0000, 32'h0);

        // R4 / R5: enable with bit 30 set
        reg_write(8'h20, 32'hFFFF_FFFF);
        reg_check(8'h20, "R4", 32'hFFE0_0000);
        reg_check(8'h24, "R5", 32'h4000_0000);

        // R9 / R10 / R11: decode
        decode_check(32'h0010_0000, "R10", 4'b0001, 32'h0010_0000);
        decode_check(32'h007F_FFFF, "R11", 4'b0001, 32'h007F_FFFF);
        decode_check(32'h0090_0000, "R10", 4'b0010, 32'h0010_0000);
        decode_check(32'h00C0_0000, "R9", 4'b0100, 32'h00C0_0000);
        decode_check(32'h0FFF_FFFF, "R9", 4'b0100, 32'h0FFF_FFFF);
        decode_check(32'h1000_0000, "R9", 4'b0000, 32'h0);
        decode_check(32'hFF90_0000, "R9", 4'b0000, 32'h0);

        // pseudo-random addresses against the model
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(posedge clk); #1 sys_addr = lfsr & 32'h1FFF_FFFF;
        end

        // R4 / R5: disable
        reg_write(8'h20, 32'h0000_0000);
        reg_check(8'h24, "R4", 32'h8000_0000);
        decode_check(32'h0010_0000, "R9", 4'b0000, 32'h0);

        // R7: ECC error status and interrupt
        reg_write(8'h98, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R7", "irq after nonzero write", 32'(ecc_irq), 32'd1);
        reg_check(8'h98, "R7", 32'hFFF0_F000);
        reg_write(8'h98, 32'h000F_0FFF);
        @(negedge clk);
        check("R7", "irq after masked-zero write", 32'(ecc_irq), 32'd0);

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule